// File: doc/BRIEF.md
# I2C Bus Timing Compliance Monitor

This block watches the clock and data lines of a two-wire I2C bus without driving them. Both lines pass through a two-stage synchroniser, and their edges are detected. A small state machine follows the bus through its phases: not yet synchronised, idle, start held, and transfer. Each time an edge closes a timed interval, the monitor compares the interval in system clock cycles with the minimum for the selected speed grade. The two speed grades are standard (100 kHz) and fast (400 kHz).

Each minimum is given in nanoseconds and converted to cycles as ceil(ns × CLK_HZ / 1e9). Every kind of breach has its own single-cycle strobe and its own sticky flag. A flag is cleared by writing a one to the matching clear bit. Separate strobes mark each detected start (including a repeated start) and each stop. No timing check runs until the first stop after reset, so the monitor can join a bus that is already busy.

States and transitions of the state machine:
- `ST_UNSYNC` goes to `ST_IDLE` on a stop.
- `ST_IDLE` goes to `ST_HOLD` on a start.
- `ST_HOLD` goes to `ST_XFER` on the first clock fall.
- `ST_HOLD` goes to `ST_IDLE` on a stop.
- `ST_XFER` goes to `ST_HOLD` on a repeated start.
- `ST_XFER` goes to `ST_IDLE` on a stop.
- Any other event leaves the state unchanged.

Top module: `i2c_timing_mon`

## Requirements
- R1: While reset is held and directly after it, `viol_pulse`, `viol_sticky`, `start_evt` and `stop_evt` are all zero.
- R2: Detection is defined on the line levels as follows.
  - A data fall while the clock is high and not changing is a start. It gives a one-cycle `start_evt`.
  - A data rise under the same condition is a stop. It gives a one-cycle `stop_evt`.
  - Each strobe comes three clock cycles after the input change. The same latency applies to `viol_pulse`.
- R3: Before the first stop after reset, no violation strobe or sticky bit is raised, whatever the line timing.
- R4: Clock-low time is measured from a clock fall to the next clock rise during a transfer. It is checked against 4700/1300 ns (standard/fast), and a breach sets bit 0. Clock-high time is measured from a clock rise to the next clock fall after a start. It is checked against 4000/600 ns, and a breach sets bit 1.
- R5: Data setup is checked at a clock rise during a transfer when the data line changed during that low phase. The time since the data edge must be at least 250/100 ns, or bit 2 is set.
- R6: Start hold is the time from the start's data fall to the first clock fall. It must be at least 4000/600 ns, or bit 3 is set.
- R7: Repeated-start setup is the time from the clock rise to a start seen during a transfer. It must be at least 4700/600 ns, or bit 4 is set.
- R8: Stop setup is the time from the clock rise to the stop's data rise. It must be at least 4700/600 ns, or bit 5 is set.
- R9: Bus free time is the time from a stop to the next start. It must be at least 4700/1300 ns, or bit 6 is set.
- R10: Bit 7 (protocol error) is set once the monitor is synchronised in either of two cases:
  - both lines change in the same sample;
  - the clock falls while the bus is idle.
  No timing check is made on such an event.
- R11: A sticky bit stays set until a cycle in which its `viol_clr` bit is one. If a new breach and a clear reach the same bit in the same cycle, the bit stays set.
- R12: An interval exactly equal to the cycle limit passes. One cycle shorter is a breach. The limit is ceil(ns × CLK_HZ / 1e9), which with the default 200 MHz gives 940/260 cycles for clock-low time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level (asynchronous) |
| sda_in | input | 1 | Bus data line level (asynchronous) |
| fast_mode | input | 1 | 1 selects fast-grade limits, 0 standard |
| viol_clr | input | 8 | Write-one-to-clear for sticky bits |
| viol_pulse | output | 8 | One-cycle breach strobes, bit map as in R4 to R10 |
| viol_sticky | output | 8 | Sticky breach flags |
| start_evt | output | 1 | Start or repeated start detected |
| stop_evt | output | 1 | Stop detected |

## Verification
A fresh breach and a software clear of the same sticky bit can arrive on the same clock edge. To provoke this, the bench shortens a clock-low phase by one cycle. It then raises the whole clear vector exactly two falling edges after driving the offending clock rise, so the clear meets the breach registration. The sticky vector must then hold only the new bit, while every older bit is gone. A second coincidence is both lines toggling in one sample; this must give a protocol error and nothing else.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    localparam int NV = 8;

    localparam int V_LOW    = 0;
    localparam int V_HIGH   = 1;
    localparam int V_SU_DAT = 2;
    localparam int V_HD_STA = 3;
    localparam int V_SU_STA = 4;
    localparam int V_SU_STO = 5;
    localparam int V_BUF    = 6;
    localparam int V_PROTO  = 7;

    typedef enum logic [1:0] {
        ST_UNSYNC,
        ST_IDLE,
        ST_HOLD,
        ST_XFER
    } bus_st_t;

    function automatic longint lim_ns(input int idx, input bit fast);
        case (idx)
            V_LOW:    return fast ? 64'd1300 : 64'd4700;
            V_HIGH:   return fast ? 64'd600  : 64'd4000;
            V_SU_DAT: return fast ? 64'd100  : 64'd250;
            V_HD_STA: return fast ? 64'd600  : 64'd4000;
            V_SU_STA: return fast ? 64'd600  : 64'd4700;
            V_SU_STO: return fast ? 64'd600  : 64'd4700;
            V_BUF:    return fast ? 64'd1300 : 64'd4700;
            default:  return 64'd0;
        endcase
    endfunction

    function automatic longint ns_to_cyc(input longint ns, input longint hz);
        return (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    endfunction

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~prev_q;
    assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/i2cmon_span.sv
module i2cmon_span #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] span
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            span <= TOP;
        else if (restart)
            span <= W'(1);
        else if (span != TOP)
            span <= span + W'(1);
    end
endmodule

// File: rtl/i2cmon_ctrl.sv
module i2cmon_ctrl
    import i2cmon_pkg::*;
#(
    parameter int W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_rise,
    input  logic          sda_fall,
    input  logic [W-1:0]  scl_span,
    input  logic [W-1:0]  sda_span,
    input  logic [W-1:0]  lim [NV-1],
    output logic [NV-1:0] viol_now,
    output logic          start_now,
    output logic          stop_now
);
    bus_st_t st, st_nx;
    logic    moved;
    logic    scl_edge, sda_edge, both;

    assign scl_edge  = scl_rise | scl_fall;
    assign sda_edge  = sda_rise | sda_fall;
    assign both      = scl_edge & sda_edge;
    assign start_now = sda_fall & scl_lvl & ~scl_edge;
    assign stop_now  = sda_rise & scl_lvl & ~scl_edge;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_UNSYNC;
            moved <= 1'b0;
        end else begin
            st <= st_nx;
            if (scl_rise)
                moved <= 1'b0;
            else if (st == ST_XFER && sda_edge && !scl_lvl && !scl_edge)
                moved <= 1'b1;
        end
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_UNSYNC: if (stop_now) st_nx = ST_IDLE;
            ST_IDLE:   if (!both && start_now) st_nx = ST_HOLD;
            ST_HOLD: begin
                if (!both && scl_fall)      st_nx = ST_XFER;
                else if (!both && stop_now) st_nx = ST_IDLE;
            end
            ST_XFER: begin
                if (!both && start_now)     st_nx = ST_HOLD;
                else if (!both && stop_now) st_nx = ST_IDLE;
            end
        endcase
    end

    // outputs: interval checks
    always_comb begin
        viol_now = '0;
        unique case (st)
            ST_UNSYNC: ;
            ST_IDLE: begin
                if (both || scl_fall)
                    viol_now[V_PROTO] = 1'b1;
                else if (start_now)
                    viol_now[V_BUF] = sda_span < lim[V_BUF];
            end
            ST_HOLD: begin
                if (both)
                    viol_now[V_PROTO] = 1'b1;
                else if (scl_fall) begin
                    viol_now[V_HIGH]   = scl_span < lim[V_HIGH];
                    viol_now[V_HD_STA] = sda_span < lim[V_HD_STA];
                end else if (stop_now)
                    viol_now[V_SU_STO] = scl_span < lim[V_SU_STO];
            end
            ST_XFER: begin
                if (both)
                    viol_now[V_PROTO] = 1'b1;
                else begin
                    if (scl_rise) begin
                        viol_now[V_LOW]    = scl_span < lim[V_LOW];
                        viol_now[V_SU_DAT] = moved && (sda_span < lim[V_SU_DAT]);
                    end
                    if (scl_fall)
                        viol_now[V_HIGH] = scl_span < lim[V_HIGH];
                    if (start_now)
                        viol_now[V_SU_STA] = scl_span < lim[V_SU_STA];
                    if (stop_now)
                        viol_now[V_SU_STO] = scl_span < lim[V_SU_STO];
                end
            end
        endcase
    end
endmodule

// File: rtl/i2c_timing_mon.sv
module i2c_timing_mon
    import i2cmon_pkg::*;
#(
    parameter int unsigned CLK_HZ = 200_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic          fast_mode,
    input  logic [NV-1:0] viol_clr,
    output logic [NV-1:0] viol_pulse,
    output logic [NV-1:0] viol_sticky,
    output logic          start_evt,
    output logic          stop_evt
);
    localparam longint MAXC = ns_to_cyc(64'd4700, longint'(CLK_HZ));
    localparam int     CW   = $clog2(MAXC + 1) + 1;

    logic          scl_lvl, scl_rise, scl_fall;
    logic          sda_lvl, sda_rise, sda_fall;
    logic [CW-1:0] scl_span, sda_span;
    logic [CW-1:0] lim [NV-1];
    logic [NV-1:0] viol_now;
    logic          start_now, stop_now;

    i2cmon_sync u_scl (.clk(clk), .rst_n(rst_n), .line_in(scl_in),
                       .level(scl_lvl), .rise(scl_rise), .fall(scl_fall));
    i2cmon_sync u_sda (.clk(clk), .rst_n(rst_n), .line_in(sda_in),
                       .level(sda_lvl), .rise(sda_rise), .fall(sda_fall));

    i2cmon_span #(.W(CW)) u_scl_span (.clk(clk), .rst_n(rst_n),
                       .restart(scl_rise | scl_fall), .span(scl_span));
    i2cmon_span #(.W(CW)) u_sda_span (.clk(clk), .rst_n(rst_n),
                       .restart(sda_rise | sda_fall), .span(sda_span));

    for (genvar i = 0; i < NV - 1; i++) begin : g_lim
        localparam longint CS = ns_to_cyc(lim_ns(i, 1'b0), longint'(CLK_HZ));
        localparam longint CF = ns_to_cyc(lim_ns(i, 1'b1), longint'(CLK_HZ));
        assign lim[i] = fast_mode ? CW'(CF) : CW'(CS);
    end

    i2cmon_ctrl #(.W(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_rise(sda_rise), .sda_fall(sda_fall),
        .scl_span(scl_span), .sda_span(sda_span), .lim(lim),
        .viol_now(viol_now), .start_now(start_now), .stop_now(stop_now)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_pulse  <= '0;
            viol_sticky <= '0;
            start_evt   <= 1'b0;
            stop_evt    <= 1'b0;
        end else begin
            viol_pulse  <= viol_now;
            viol_sticky <= (viol_sticky & ~viol_clr) | viol_now;
            start_evt   <= start_now;
            stop_evt    <= stop_now;
        end
    end

    logic unused_lvl;
    assign unused_lvl = sda_lvl;
endmodule

// File: rtl/i2cmon_chk.sv
module i2cmon_chk
    import i2cmon_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [NV-1:0] viol_clr,
    input logic [NV-1:0] viol_pulse,
    input logic [NV-1:0] viol_sticky,
    input logic          start_evt,
    input logic          stop_evt
);
    logic seen_stop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        seen_stop <= 1'b0;
        else if (stop_evt) seen_stop <= 1'b1;
    end

    for (genvar i = 0; i < NV; i++) begin : g_bit
        // R11
        pulse_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            viol_pulse[i] |-> viol_sticky[i]);
        // R11
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(viol_sticky[i]) |-> $past(viol_clr[i]));
    end

    // R2
    evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_evt && stop_evt));

    // R2
    start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !start_evt);

    // R3
    unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_stop |-> (viol_pulse == '0));
endmodule

bind i2c_timing_mon i2cmon_chk u_chk (
    .clk(clk), .rst_n(rst_n), .viol_clr(viol_clr), .viol_pulse(viol_pulse),
    .viol_sticky(viol_sticky), .start_evt(start_evt), .stop_evt(stop_evt)
);

// File: tb/sim_i2c_timing_mon.sv
`timescale 1ns/1ps
module sim_i2c_timing_mon;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1, fm = 1'b0;
    logic [7:0] clr = '0;
    logic [7:0] vp, vs;
    logic       sev, pev;

    int checks = 0, errors = 0;
    int cyc = 0;

    // bench model state
    int         mst = 0;          // 0 unsync, 1 idle, 2 hold, 3 xfer
    int         t_scl = -100000, t_sda = -100000;
    bit         mmoved = 0;
    logic [7:0] exp_s = '0;

    i2c_timing_mon u0 (.clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .fast_mode(fm), .viol_clr(clr), .viol_pulse(vp), .viol_sticky(vs),
        .start_evt(sev), .stop_evt(pev));

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // limit in cycles at 200 MHz: ceil(ns / 5)
    function automatic int blim(input int idx, input bit f);
        int ns;
        case (idx)
            0: ns = f ? 1300 : 4700;
            1: ns = f ? 600  : 4000;
            2: ns = f ? 100  : 250;
            3: ns = f ? 600  : 4000;
            4: ns = f ? 600  : 4700;
            5: ns = f ? 600  : 4700;
            default: ns = f ? 1300 : 4700;
        endcase
        return (ns + 4) / 5;
    endfunction

    function automatic int pick(input int l);
        int r;
        int v;
        r = $urandom_range(0, 5);
        if (r == 0) begin
            v = l - 1 - $urandom_range(0, l / 4);
            return (v < 1) ? 1 : v;
        end
        return l + $urandom_range(0, l / 3);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic idle_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive line levels (call at a falling edge) and update the model
    task automatic setl(input logic c, input logic d);
        bit sce, sde, sr, sf, st, sp;
        int dc, dd;
        sce = (c != scl); sde = (d != sda);
        sr = sce & c; sf = sce & !c;
        st = sde & !d & c & !sce;
        sp = sde & d & c & !sce;
        dc = cyc - t_scl; dd = cyc - t_sda;
        if (mst != 0 && sce && sde) exp_s[7] = 1'b1;          // R10
        else case (mst)
            0: if (sp) mst = 1;
            1: if (sf) exp_s[7] = 1'b1;                       // R10
               else if (st) begin
                   if (dd < blim(6, fm)) exp_s[6] = 1'b1;     // R9
                   mst = 2;
               end
            2: if (sf) begin
                   if (dc < blim(1, fm)) exp_s[1] = 1'b1;     // R4
                   if (dd < blim(3, fm)) exp_s[3] = 1'b1;     // R6
                   mst = 3;
               end else if (sp) begin
                   if (dc < blim(5, fm)) exp_s[5] = 1'b1;     // R8
                   mst = 1;
               end
            default: begin
                if (sr) begin
                    if (dc < blim(0, fm)) exp_s[0] = 1'b1;    // R4
                    if (mmoved && dd < blim(2, fm)) exp_s[2] = 1'b1; // R5
                end
                if (sf && dc < blim(1, fm)) exp_s[1] = 1'b1;  // R4
                if (st) begin
                    if (dc < blim(4, fm)) exp_s[4] = 1'b1;    // R7
                    mst = 2;
                end
                if (sp) begin
                    if (dc < blim(5, fm)) exp_s[5] = 1'b1;    // R8
                    mst = 1;
                end
            end
        endcase
        if (sr) mmoved = 0;
        else if (mst == 3 && sde && !c && !sce) mmoved = 1;
        if (sce) t_scl = cyc;
        if (sde) t_sda = cyc;
        scl = c; sda = d;
    endtask

    task automatic clr_all();
        clr = '1; idle_n(1); clr = '0; idle_n(1);
        chk(vs == 8'h00, "R11 clear", vs, 0);
        exp_s = '0;
    endtask

    task automatic bits(input int nb);
        for (int k = 0; k < nb; k++) begin
            int lo, b, a;
            logic bv;
            bv = 1'($urandom_range(0, 1));
            lo = pick(blim(0, fm)); b = pick(blim(2, fm));
            a = lo - b; if (a < 1) a = 1;
            idle_n(a); setl(0, bv);
            idle_n(b); setl(1, bv);
            idle_n(pick(blim(1, fm))); setl(0, bv);
        end
    endtask

    task automatic close(input bit rep);
        int lo, b, a;
        logic tg;
        tg = rep;
        lo = pick(blim(0, fm)); b = pick(blim(2, fm));
        a = lo - b; if (a < 1) a = 1;
        idle_n(a); setl(0, tg);
        idle_n(b); setl(1, tg);
        idle_n(pick(blim(rep ? 4 : 5, fm))); setl(1, !tg);
    endtask

    task automatic frame(input int nb, input bit rep);
        idle_n(pick(blim(6, fm))); setl(1, 0);
        idle_n(pick(blim(3, fm))); setl(0, 0);
        bits(nb);
        if (rep) begin
            close(1);
            idle_n(pick(blim(3, fm))); setl(0, 0);
            bits(1);
        end
        close(0);
        idle_n(5);
        chk(vs == exp_s, "R4-R9 frame sticky", vs, exp_s);
        clr_all();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_n(4);
        // R1
        chk(vp == 0 && vs == 0 && !sev && !pev, "R1 reset", {vp, vs, 6'd0, sev, pev}, 0);
        rst_n = 1'b1;
        idle_n(3);
        chk(vp == 0 && vs == 0 && !sev && !pev, "R1 after reset", {vp, vs, 6'd0, sev, pev}, 0);

        // R3 unarmed activity with short intervals, R2 strobe timing
        setl(1, 0); idle_n(3);
        chk(sev == 1'b1, "R2 start strobe", sev, 1);
        idle_n(1);
        chk(sev == 1'b0, "R2 start one cycle", sev, 0);
        setl(0, 0); idle_n(4); setl(1, 0); idle_n(4);
        setl(1, 1); idle_n(3);
        chk(pev == 1'b1, "R2 stop strobe", pev, 1);
        idle_n(1);
        chk(pev == 1'b0 && vs == 0, "R3 no check before first stop", {pev, vs}, 0);

        // R12 boundary, fast grade
        fm = 1'b1;
        idle_n(300); setl(1, 0);
        idle_n(150); setl(0, 0);
        idle_n(260); setl(1, 0);
        idle_n(3);
        chk(vp == 8'h00, "R12 low equal to limit", vp, 0);
        idle_n(130); setl(0, 0);
        idle_n(259); setl(1, 0);
        idle_n(2); clr = '1; idle_n(1); clr = '0;
        chk(vp == 8'h01, "R12 R4 low one short", vp, 8'h01);
        chk(vs == 8'h01, "R11 set wins over clear", vs, 8'h01);
        exp_s = 8'h01;
        clr = 8'h01; idle_n(1); clr = '0; idle_n(1);
        chk(vs == 8'h00, "R11 single bit clear", vs, 0);
        exp_s = '0;

        // R10 simultaneous edges during a transfer
        idle_n(150); setl(0, 1);
        idle_n(3);
        chk(vp == 8'h80, "R10 both lines in one sample", vp, 8'h80);
        idle_n(300); setl(0, 0);
        idle_n(300); setl(1, 0);
        idle_n(150); setl(1, 1);
        idle_n(5);
        chk(vs == exp_s, "R10 frame sticky", vs, exp_s);
        clr_all();

        // R10 clock fall while idle
        idle_n(300); setl(0, 1);
        idle_n(300); setl(1, 1);
        idle_n(5);
        chk(vs == 8'h80 && exp_s == 8'h80, "R10 idle clock fall", vs, 8'h80);
        clr_all();

        // random frames, fast then standard grade
        for (int f = 0; f < 16; f++) frame($urandom_range(1, 3), f[1]);
        fm = 1'b0;
        idle_n(1);
        for (int f = 0; f < 3; f++) frame(2, f == 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule